// File: doc/BRIEF.md
# Two-Level Data Address Translation Cache

This block caches virtual-to-physical page translations for a core that runs two hardware threads. Each lookup carries a thread bit and a virtual page number (VPN) and, on a hit, returns the physical page number (PPN) with the page size. The first level has two fully associative arrays that are searched in parallel. One holds 4 KiB translations. The other holds 2 MiB and 4 MiB translations. Behind the first level sits a larger second-level array that holds only 4 KiB translations.

Every entry is tagged with the thread that installed it. Either thread may occupy any slot, and a lookup can hit only on entries that carry its own thread bit. A lookup that misses the first level probes the second level. If that also misses, the block raises one request to an external page walker and waits for its answer. Only one miss is in flight at a time. While it is pending, `lk_ready` stays low. A per-thread flush wipes every translation of one thread from both levels in one cycle.

Top module: `dtlb2_xlate`

## Requirements
- R1: After reset no entry is valid, `lk_ready` is 1, and `walk_req` and `rsp_valid` are 0. The first lookup of any page goes to the walker.
- R2: A lookup accepted on a clock edge (`lk_valid` and `lk_ready` both high) that hits in the first level raises `rsp_valid` with `rsp_hit`=1 after that same edge, one cycle of latency. A hit does not drop `lk_ready`.
- R3: Page size code on `rsp_size` and `walk_rsp_size` is 0 for 4 KiB, 1 for 2 MiB and 2 for 4 MiB. A 2 MiB entry matches on VPN bits above bit 8, and the returned PPN takes bits 8..0 from the lookup VPN. A 4 MiB entry matches above bit 9, and the PPN takes bits 9..0 from the VPN.
- R4: A first-level miss probes the second level in the following cycle. On a hit there, the response appears two cycles after acceptance, and the translation is copied into the first-level 4 KiB array, so that a repeat lookup hits with one cycle of latency.
- R5: When both levels miss, `walk_req` rises with `walk_tid` and `walk_vpn` equal to the missing lookup. It stays high and unchanged until a cycle with `walk_rsp_valid`. The response is presented in the cycle after `walk_rsp_valid`.
- R6: A successful walk response installs the translation in the first-level array for its size. A 4 KiB page is also installed in the second level. A large page never enters the second level, so once it is evicted from the first level, a later lookup walks again.
- R7: Each array picks its victim round-robin. In an array of N slots, fill number N+1 overwrites the slot written by fill number 1, whether or not other slots are invalid.
- R8: A lookup from one thread never hits a translation installed by the other thread, even for the same VPN.
- R9: A cycle with `flush_valid` invalidates every entry tagged `flush_tid` in both levels. Entries of the other thread are kept.
- R10: From acceptance of a lookup that misses the first level until its response, `lk_ready` is 0. A lookup offered in that window is ignored: it gets no response and starts no walk.
- R11: A walk response with `walk_rsp_ok`=0 produces a response with `rsp_hit`=0 and installs nothing, so a repeat lookup walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Block can accept a lookup this cycle |
| lk_tid | input | 1 | Thread of the lookup |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number, with VPN low bits filled in for large pages |
| rsp_size | output | 2 | Page size code (0 = 4 KiB, 1 = 2 MiB, 2 = 4 MiB) |
| walk_req | output | 1 | Request to the page walker, held until answered |
| walk_tid | output | 1 | Thread of the walk |
| walk_vpn | output | VPN_W | VPN to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ok | input | 1 | Walker found a valid mapping |
| walk_rsp_ppn | input | PPN_W | Page-aligned physical page number |
| walk_rsp_size | input | 2 | Page size code of the mapping |
| flush_valid | input | 1 | Flush one thread's translations |
| flush_tid | input | 1 | Thread to flush |

## Verification
Lookups are classified by the cycle in which the response appears and by whether a walk was requested. This separates first-level hits, second-level hits and walks, so each test can confirm which level answered as well as what it returned. Repeated VPNs are tried from both threads to separate thread tagging from plain address matching. Large-page VPNs that differ only in low bits distinguish the 2 MiB and 4 MiB match widths. Fill sequences one longer than a small array is deep, together with a flush of one thread, show which slots round-robin replacement overwrote and what the flush kept.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L2   = 2'd1,
        ST_WALK = 2'd2
    } ctl_st_e;

    // Mask of the page-number bits that lie inside a page of the given size.
    function automatic logic [9:0] in_page_mask(pg_size_e sz);
        case (sz)
            PG_2M:   return 10'h1FF;
            PG_4M:   return 10'h3FF;
            default: return 10'h000;
        endcase
    endfunction

endpackage

// File: rtl/xlat_fa_array.sv
module xlat_fa_array
    import tlb2_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_tid,
    input  logic [VPN_W-1:0] q_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output pg_size_e         hit_size,
    input  logic             fill_en,
    input  logic             fill_tid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  pg_size_e         fill_size,
    input  logic             flush_en,
    input  logic             flush_tid
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             vld;
        logic             tid;
        pg_size_e         size;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   rr;
    } arr_t;

    arr_t s_d, s_q;

    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] live_t0, live_t1;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] vmask;
        assign vmask      = VPN_W'(in_page_mask(s_q.ent[g].size));
        assign match[g]   = s_q.ent[g].vld && (s_q.ent[g].tid == q_tid) &&
                            (((s_q.ent[g].vpn ^ q_vpn) & ~vmask) == '0);
        assign live_t0[g] = s_q.ent[g].vld && !s_q.ent[g].tid;
        assign live_t1[g] = s_q.ent[g].vld &&  s_q.ent[g].tid;
    end

    logic [IDX_W-1:0] sel;
    ent_t             sel_ent;
    logic [PPN_W-1:0] pmask;

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
        sel_ent  = s_q.ent[sel];
        pmask    = PPN_W'(in_page_mask(sel_ent.size));
        hit      = |match;
        hit_size = sel_ent.size;
        hit_ppn  = (sel_ent.ppn & ~pmask) | (PPN_W'(q_vpn[9:0]) & pmask);
    end

    always_comb begin
        s_d = s_q;
        if (flush_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_q.ent[i].tid == flush_tid) s_d.ent[i].vld = 1'b0;
            end
        end
        if (fill_en) begin
            s_d.ent[s_q.rr] = '{vld: 1'b1, tid: fill_tid, size: fill_size,
                                vpn: fill_vpn, ppn: fill_ppn};
            s_d.rr = (s_q.rr == LAST_IDX) ? '0 : s_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    flush_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en && !fill_en && !flush_tid |=> live_t0 == '0);
    // R9
    flush_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en && !fill_en && flush_tid |=> live_t1 == '0);
    // R7
    rr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> s_q.rr != $past(s_q.rr));
    // R7
    rr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(s_q.rr));

endmodule

// File: rtl/dtlb2_xlate.sv
module dtlb2_xlate
    import tlb2_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PPN_W = 28,
    parameter int L1S_N = 64,
    parameter int L1L_N = 32,
    parameter int L2_N  = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    output logic             lk_ready,
    input  logic             lk_tid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [1:0]       rsp_size,
    output logic             walk_req,
    output logic             walk_tid,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_ok,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    input  logic [1:0]       walk_rsp_size,
    input  logic             flush_valid,
    input  logic             flush_tid
);

    typedef struct packed {
        ctl_st_e          st;
        logic             ptid;
        logic [VPN_W-1:0] pvpn;
        logic             rsp_v;
        logic             rsp_hit;
        logic [PPN_W-1:0] rsp_ppn;
        pg_size_e         rsp_size;
        logic             wreq;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             s1_hit, l1_hit, l2_hit;
    logic [PPN_W-1:0] s1_ppn, l1_ppn, l2_ppn;
    pg_size_e         s1_size, l1_size, l2_size;

    logic             s1_fill, l1_fill, l2_fill;
    logic [PPN_W-1:0] fill_ppn;
    logic             fill_tid;
    logic [VPN_W-1:0] fill_vpn;

    pg_size_e         w_size;
    logic [PPN_W-1:0] w_mask;

    assign w_size = pg_size_e'(walk_rsp_size);
    assign w_mask = PPN_W'(in_page_mask(w_size));

    xlat_fa_array #(.ENTRIES(L1S_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_l1_small (
        .clk(clk), .rst_n(rst_n),
        .q_tid(lk_tid), .q_vpn(lk_vpn),
        .hit(s1_hit), .hit_ppn(s1_ppn), .hit_size(s1_size),
        .fill_en(s1_fill), .fill_tid(fill_tid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(PG_4K),
        .flush_en(flush_valid), .flush_tid(flush_tid)
    );

    xlat_fa_array #(.ENTRIES(L1L_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_l1_large (
        .clk(clk), .rst_n(rst_n),
        .q_tid(lk_tid), .q_vpn(lk_vpn),
        .hit(l1_hit), .hit_ppn(l1_ppn), .hit_size(l1_size),
        .fill_en(l1_fill), .fill_tid(fill_tid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(w_size),
        .flush_en(flush_valid), .flush_tid(flush_tid)
    );

    xlat_fa_array #(.ENTRIES(L2_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_l2 (
        .clk(clk), .rst_n(rst_n),
        .q_tid(c_q.ptid), .q_vpn(c_q.pvpn),
        .hit(l2_hit), .hit_ppn(l2_ppn), .hit_size(l2_size),
        .fill_en(l2_fill), .fill_tid(fill_tid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(PG_4K),
        .flush_en(flush_valid), .flush_tid(flush_tid)
    );

    always_comb begin
        c_d         = c_q;
        c_d.rsp_v   = 1'b0;
        s1_fill     = 1'b0;
        l1_fill     = 1'b0;
        l2_fill     = 1'b0;
        fill_tid    = c_q.ptid;
        fill_vpn    = c_q.pvpn;
        fill_ppn    = walk_rsp_ppn;
        case (c_q.st)
            ST_IDLE: begin
                if (lk_valid) begin
                    if (s1_hit || l1_hit) begin
                        c_d.rsp_v    = 1'b1;
                        c_d.rsp_hit  = 1'b1;
                        c_d.rsp_ppn  = s1_hit ? s1_ppn : l1_ppn;
                        c_d.rsp_size = s1_hit ? s1_size : l1_size;
                    end else begin
                        c_d.st   = ST_L2;
                        c_d.ptid = lk_tid;
                        c_d.pvpn = lk_vpn;
                    end
                end
            end
            ST_L2: begin
                if (l2_hit) begin
                    c_d.rsp_v    = 1'b1;
                    c_d.rsp_hit  = 1'b1;
                    c_d.rsp_ppn  = l2_ppn;
                    c_d.rsp_size = l2_size;
                    c_d.st       = ST_IDLE;
                    s1_fill      = 1'b1;
                    fill_ppn     = l2_ppn;
                end else begin
                    c_d.wreq = 1'b1;
                    c_d.st   = ST_WALK;
                end
            end
            ST_WALK: begin
                if (walk_rsp_valid) begin
                    c_d.wreq    = 1'b0;
                    c_d.st      = ST_IDLE;
                    c_d.rsp_v   = 1'b1;
                    c_d.rsp_hit = walk_rsp_ok;
                    if (walk_rsp_ok) begin
                        c_d.rsp_size = w_size;
                        c_d.rsp_ppn  = (walk_rsp_ppn & ~w_mask) |
                                       (PPN_W'(c_q.pvpn[9:0]) & w_mask);
                        s1_fill      = (w_size == PG_4K);
                        l2_fill      = (w_size == PG_4K);
                        l1_fill      = (w_size != PG_4K);
                    end else begin
                        c_d.rsp_size = PG_4K;
                        c_d.rsp_ppn  = '0;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign lk_ready  = (c_q.st == ST_IDLE);
    assign rsp_valid = c_q.rsp_v;
    assign rsp_hit   = c_q.rsp_hit;
    assign rsp_ppn   = c_q.rsp_ppn;
    assign rsp_size  = c_q.rsp_size;
    assign walk_req  = c_q.wreq;
    assign walk_tid  = c_q.ptid;
    assign walk_vpn  = c_q.pvpn;

    // R2
    l1_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready && (s1_hit || l1_hit) |=> rsp_valid && rsp_hit && lk_ready);
    // R4
    l2_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_L2) && l2_hit |=> rsp_valid && rsp_hit && (rsp_size == 2'd0));
    // R5
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_rsp_valid |=> walk_req && $stable(walk_vpn) && $stable(walk_tid));
    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !lk_ready);
    // R6
    l2_small_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_fill |-> s1_fill && !l1_fill);

endmodule

// File: tb/test_dtlb2_xlate.sv
module test_dtlb2_xlate;

    localparam int VPN_W = 20;
    localparam int PPN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic             lk_ready;
    logic             lk_tid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             rsp_valid, rsp_hit;
    logic [PPN_W-1:0] rsp_ppn;
    logic [1:0]       rsp_size;
    logic             walk_req, walk_tid;
    logic [VPN_W-1:0] walk_vpn;
    logic             walk_rsp_valid = 1'b0;
    logic             walk_rsp_ok = 1'b0;
    logic [PPN_W-1:0] walk_rsp_ppn = '0;
    logic [1:0]       walk_rsp_size = '0;
    logic             flush_valid = 1'b0;
    logic             flush_tid = 1'b0;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    dtlb2_xlate #(.VPN_W(VPN_W), .PPN_W(PPN_W), .L1S_N(4), .L1L_N(2), .L2_N(8)) i_dtlb2_xlate (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_tid(lk_tid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_size(rsp_size),
        .walk_req(walk_req), .walk_tid(walk_tid), .walk_vpn(walk_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ok(walk_rsp_ok),
        .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_size(walk_rsp_size),
        .flush_valid(flush_valid), .flush_tid(flush_tid)
    );

    localparam int K_L1 = 0, K_L2 = 1, K_WALK = 2;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one lookup, answer a walk if one is raised, classify which level answered.
    task automatic lookup(bit tid, logic [VPN_W-1:0] vpn, int exp_kind,
                          logic [PPN_W-1:0] wppn, logic [1:0] wsz, bit wok,
                          bit exp_hit, logic [PPN_W-1:0] exp_ppn, logic [1:0] exp_sz,
                          string req);
        int cyc;
        int kind;
        bit walked;
        @(negedge clk);
        chk(lk_ready == 1'b1, req, "ready before lookup", lk_ready, 1);
        lk_valid = 1'b1; lk_tid = tid; lk_vpn = vpn;
        @(negedge clk);
        lk_valid = 1'b0;
        cyc = 1; walked = 1'b0;
        while (!rsp_valid && cyc < 40) begin
            if (walk_req && !walked) begin
                chk(walk_vpn == vpn && walk_tid == tid, "R5", "walk address", walk_vpn, vpn);
                chk(lk_ready == 1'b0, "R10", "ready during walk", lk_ready, 0);
                walk_rsp_valid = 1'b1; walk_rsp_ok = wok;
                walk_rsp_ppn = wppn; walk_rsp_size = wsz;
                walked = 1'b1;
                @(negedge clk);
                walk_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
            cyc++;
        end
        kind = walked ? K_WALK : (cyc == 1 ? K_L1 : (cyc == 2 ? K_L2 : 9));
        chk(kind == exp_kind, req, "answering level", kind, exp_kind);
        chk(rsp_valid && rsp_hit == exp_hit, req, "hit flag", rsp_hit, exp_hit);
        if (exp_hit) begin
            chk(rsp_ppn == exp_ppn, req, "ppn", rsp_ppn, exp_ppn);
            chk(rsp_size == exp_sz, req, "size", rsp_size, exp_sz);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(lk_ready == 1'b1, "R1", "ready after reset", lk_ready, 1);
        chk(walk_req == 1'b0, "R1", "walk_req after reset", walk_req, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    endtask

    task automatic test_small_fill_hit();
        lookup(0, 20'h00100, K_WALK, 16'h0A00, 2'd0, 1, 1, 16'h0A00, 2'd0, "R1");
        lookup(0, 20'h00100, K_L1, '0, 2'd0, 1, 1, 16'h0A00, 2'd0, "R2");
    endtask

    task automatic test_large_pages();
        lookup(0, 20'h40203, K_WALK, 16'h1200, 2'd1, 1, 1, 16'h1203, 2'd1, "R3");
        lookup(0, 20'h40300, K_L1, '0, 2'd0, 1, 1, 16'h1300, 2'd1, "R3");
        lookup(0, 20'h80005, K_WALK, 16'h2400, 2'd2, 1, 1, 16'h2405, 2'd2, "R3");
        lookup(0, 20'h803FF, K_L1, '0, 2'd0, 1, 1, 16'h27FF, 2'd2, "R3");
    endtask

    task automatic test_thread_tag();
        lookup(1, 20'h00100, K_WALK, 16'h0B00, 2'd0, 1, 1, 16'h0B00, 2'd0, "R8");
        lookup(0, 20'h00100, K_L1, '0, 2'd0, 1, 1, 16'h0A00, 2'd0, "R8");
        lookup(1, 20'h00100, K_L1, '0, 2'd0, 1, 1, 16'h0B00, 2'd0, "R8");
    endtask

    task automatic test_evict_l2_refill();
        lookup(0, 20'h00200, K_WALK, 16'h0C00, 2'd0, 1, 1, 16'h0C00, 2'd0, "R6");
        lookup(0, 20'h00300, K_WALK, 16'h0D00, 2'd0, 1, 1, 16'h0D00, 2'd0, "R6");
        lookup(0, 20'h00400, K_WALK, 16'h0E00, 2'd0, 1, 1, 16'h0E00, 2'd0, "R7");
        lookup(0, 20'h00100, K_L2, '0, 2'd0, 1, 1, 16'h0A00, 2'd0, "R4");
        lookup(0, 20'h00100, K_L1, '0, 2'd0, 1, 1, 16'h0A00, 2'd0, "R4");
        lookup(1, 20'h00100, K_L2, '0, 2'd0, 1, 1, 16'h0B00, 2'd0, "R7");
    endtask

    task automatic test_large_not_in_l2();
        lookup(0, 20'hC0000, K_WALK, 16'h3000, 2'd1, 1, 1, 16'h3000, 2'd1, "R7");
        lookup(0, 20'h40203, K_WALK, 16'h1200, 2'd1, 1, 1, 16'h1203, 2'd1, "R6");
    endtask

    task automatic test_walk_fail();
        lookup(0, 20'h00500, K_WALK, 16'h0F00, 2'd0, 0, 0, '0, 2'd0, "R11");
        lookup(0, 20'h00500, K_WALK, 16'h0F00, 2'd0, 1, 1, 16'h0F00, 2'd0, "R11");
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        lk_valid = 1'b1; lk_tid = 1'b0; lk_vpn = 20'h00600;
        @(negedge clk);
        lk_vpn = 20'h00700;
        for (int i = 0; i < 3; i++) begin
            chk(lk_ready == 1'b0, "R10", "ready while miss pending", lk_ready, 0);
            @(negedge clk);
        end
        chk(walk_req == 1'b1 && walk_vpn == 20'h00600, "R10", "walk address kept",
            walk_vpn, 20'h00600);
        walk_rsp_valid = 1'b1; walk_rsp_ok = 1'b1;
        walk_rsp_ppn = 16'h1600; walk_rsp_size = 2'd0;
        @(negedge clk);
        walk_rsp_valid = 1'b0; lk_valid = 1'b0;
        chk(rsp_valid && rsp_ppn == 16'h1600, "R5", "response after walk", rsp_ppn, 16'h1600);
        @(negedge clk);
        chk(!rsp_valid && !walk_req, "R10", "no action for ignored lookup",
            {rsp_valid, walk_req}, 0);
        lookup(0, 20'h00700, K_WALK, 16'h1700, 2'd0, 1, 1, 16'h1700, 2'd0, "R10");
    endtask

    task automatic test_flush();
        @(negedge clk);
        flush_valid = 1'b1; flush_tid = 1'b1;
        @(negedge clk);
        flush_valid = 1'b0;
        lookup(0, 20'h00600, K_L1, '0, 2'd0, 1, 1, 16'h1600, 2'd0, "R9");
        lookup(0, 20'h00300, K_L2, '0, 2'd0, 1, 1, 16'h0D00, 2'd0, "R9");
        lookup(0, 20'h00100, K_L2, '0, 2'd0, 1, 1, 16'h0A00, 2'd0, "R9");
        lookup(1, 20'h00100, K_WALK, 16'h0B00, 2'd0, 1, 1, 16'h0B00, 2'd0, "R9");
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_small_fill_hit();
        test_large_pages();
        test_thread_tag();
        test_evict_l2_refill();
        test_large_not_in_l2();
        test_walk_fail();
        test_busy_ignore();
        test_flush();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule